// File: doc/BRIEF.md
# Byte Scan With Terminator

This block walks memory one byte at a time from a starting byte address. One 16-bit key word carries two bytes: a search byte, which it is looking for, and a stop byte, which ends the search early. Each byte read is first compared with the search byte and then with the stop byte. A search-byte hit ends the scan with the pointer resting on the hit. A stop-byte hit ends it one past the stop byte and raises a skip flag.

If an interrupt request is present when a byte matches neither, the scan stops after advancing the pointer and raises an interrupted flag. The caller resumes the search by starting again from the returned pointer with the same key.

The block reads through a simple port with one cycle of latency. It reports through registered outputs that are qualified by a one-cycle completion pulse. Instruction decode and the memory itself are outside the block.

Top module: `bscan_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_req_o`, `skip_o` and `intr_o` are 0 and `ptr_o` is 0x0000.
- R2: The search byte is `key_i[7:0]` and the stop byte is `key_i[15:8]`. Both are captured when a scan starts.
- R3: When the byte read equals the search byte, the scan ends with `ptr_o` equal to that byte's address, `skip_o`=0 and `intr_o`=0.
- R4: When the byte read differs from the search byte but equals the stop byte, the scan ends with `ptr_o` equal to that byte's address plus one, `skip_o`=1 and `intr_o`=0.
- R5: When the search byte and the stop byte are equal, a byte holding that value ends the scan as a search hit (R3 results).
- R6: When `irq_i` is 1 in the cycle a byte that matches neither value is returned, the scan ends with `ptr_o` equal to that address plus one, `intr_o`=1 and `skip_o`=0. A byte that matches either value takes precedence over `irq_i`. Restarting from `ptr_o` continues the search.
- R7: The pointer is a 16-bit byte address that wraps from 0xFFFF to 0x0000.
- R8: Each byte costs one read. `rd_req_o` is high for one cycle with `rd_addr_o` equal to the current pointer, and `rd_data_i` is taken in the following cycle. Successive reads of one scan use consecutive addresses, starting at `ptr_i`.
- R9: `done_o` is a single-cycle pulse and `busy_o` is 0 while it is high. `ptr_o`, `skip_o` and `intr_o` stay unchanged from the pulse until the next scan ends.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored, and the running scan completes with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a scan (accepted only when idle) |
| key_i | input | 16 | Stop byte in [15:8], search byte in [7:0] |
| ptr_i | input | 16 | First byte address to read |
| irq_i | input | 1 | Pending interrupt request |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | 16 | Byte address of the read |
| rd_data_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | 16 | Final pointer |
| skip_o | output | 1 | Scan ended on the stop byte |
| intr_o | output | 1 | Scan ended early for an interrupt |

## Verification
The assertions assume that the memory returns the addressed byte in exactly the cycle after `rd_req_o`. They also assume reset is held for more than one clock before the first check is armed. The bench's memory model registers the byte on the edge that sees the request, which meets that latency. `irq_i` and `start_i` are changed only on falling edges, so the controller sees them as stable levels in its evaluation cycle. Only the low 8 address bits index the bench memory, so the wrap case places bytes at 0xFE, 0xFF and 0x00.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EVAL = 2'd2
  } scan_state_t;

  typedef struct packed {
    logic hit_key;
    logic hit_stop;
  } cmp_t;
endpackage

// File: rtl/bscan_match.sv
module bscan_match #(
  parameter int BYTE_W = 8,
  localparam int KEY_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [KEY_W-1:0]  key,
  input  logic [BYTE_W-1:0] data,
  output bscan_pkg::cmp_t   cmp
);
  logic [BYTE_W-1:0] find_q;
  logic [BYTE_W-1:0] stop_q;

  // capture both compare values at scan start
  always_ff @(posedge clk) begin
    if (rst) begin
      find_q <= '0;
      stop_q <= '0;
    end else if (load) begin
      find_q <= key[BYTE_W-1:0];
      stop_q <= key[KEY_W-1:BYTE_W];
    end
  end

  always_comb begin
    cmp.hit_key  = (data == find_q);
    cmp.hit_stop = (data == stop_q);
  end
endmodule

// File: rtl/bscan_ptr.sv
module bscan_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_next
);
  // modulo 2^ADDR_W advance
  always_comb begin
    ptr_next = step ? ptr + ADDR_W'(1) : ptr;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else           ptr <= ptr_next;
  end
endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic irq,
  input  cmp_t cmp,
  output logic load,
  output logic rd_req,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done,
  output logic skip,
  output logic intr
);
  scan_state_t state_q;

  always_comb begin
    load   = (state_q == ST_IDLE) && start;
    rd_req = (state_q == ST_READ);
    busy   = (state_q != ST_IDLE);
    // search hit leaves the pointer on the byte; anything else advances
    step   = (state_q == ST_EVAL) && !cmp.hit_key;
    finish = (state_q == ST_EVAL) && (cmp.hit_key || cmp.hit_stop || irq);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      skip    <= 1'b0;
      intr    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_READ;
        ST_READ: state_q <= ST_EVAL;
        ST_EVAL: begin
          if (finish) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            // priority: search byte, then stop byte, then interrupt
            skip    <= !cmp.hit_key && cmp.hit_stop;
            intr    <= !cmp.hit_key && !cmp.hit_stop;
          end else begin
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bscan_unit.sv
module bscan_unit #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  localparam int KEY_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              irq_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              skip_o,
  output logic              intr_o
);
  bscan_pkg::cmp_t   cmp;
  logic              load;
  logic              step;
  logic              finish;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptr_next;

  bscan_match #(.BYTE_W(BYTE_W)) u_match (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .key  (key_i),
    .data (rd_data_i),
    .cmp  (cmp)
  );

  bscan_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (ptr_i),
    .step     (step),
    .ptr      (ptr),
    .ptr_next (ptr_next)
  );

  bscan_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start_i),
    .irq    (irq_i),
    .cmp    (cmp),
    .load   (load),
    .rd_req (rd_req_o),
    .step   (step),
    .finish (finish),
    .busy   (busy_o),
    .done   (done_o),
    .skip   (skip_o),
    .intr   (intr_o)
  );

  assign rd_addr_o = ptr;

  // final pointer captured together with the flags
  always_ff @(posedge clk) begin
    if (rst)         ptr_o <= '0;
    else if (finish) ptr_o <= ptr_next;
  end
endmodule

// File: rtl/bscan_unit_chk.sv
module bscan_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              skip_o,
  input logic              intr_o
);
  logic              armed;
  logic              have_prev;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      have_prev <= 1'b0;
      last_addr <= '0;
    end else begin
      armed <= 1'b1;
      if (start_i && !busy_o) have_prev <= 1'b0;
      else if (rd_req_o)      have_prev <= 1'b1;
      if (rd_req_o) last_addr <= rd_addr_o;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && !busy_o && !done_o) |-> ($stable(ptr_o) && $stable(skip_o) && $stable(intr_o)));
  p_req_busy_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o);
  p_addr_seq_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && have_prev) |-> (rd_addr_o == last_addr + ADDR_W'(1)));
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !(skip_o && intr_o));
  p_find_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    (done_o && !skip_o && !intr_o) |-> (ptr_o == last_addr));
  p_stop_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    (done_o && skip_o) |-> (ptr_o == last_addr + ADDR_W'(1)));
  p_intr_ptr_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && intr_o) |-> (ptr_o == last_addr + ADDR_W'(1)));
endmodule

bind bscan_unit bscan_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ptr_o     (ptr_o),
  .skip_o    (skip_o),
  .intr_o    (intr_o)
);

// File: tb/bscan_unit_bench.sv
module bscan_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [15:0] key_i;
  logic [15:0] ptr_i;
  logic        irq_i;
  logic        rd_req_o;
  logic [15:0] rd_addr_o;
  logic [7:0]  rd_data_i;
  logic        busy_o;
  logic        done_o;
  logic [15:0] ptr_o;
  logic        skip_o;
  logic        intr_o;

  int checks = 0;
  int fails  = 0;
  int nreads = 0;
  int addr_bad = 0;
  logic [15:0] exp_addr = '0;
  logic [7:0]  mem [0:255];

  always #5ns clk = ~clk;

  bscan_unit u_bscan_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i), .ptr_i(ptr_i),
    .irq_i(irq_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .ptr_o(ptr_o),
    .skip_o(skip_o), .intr_o(intr_o)
  );

  // memory model: one cycle read latency, plus read-address monitor
  always @(posedge clk) begin
    if (rd_req_o) begin
      rd_data_i <= mem[rd_addr_o[7:0]];
      if (rd_addr_o != exp_addr) addr_bad = addr_bad + 1;
      exp_addr = exp_addr + 16'd1;
      nreads   = nreads + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 8'h20;
  endtask

  task automatic launch(input logic [15:0] p, input logic [15:0] k);
    @(negedge clk);
    ptr_i = p; key_i = k; start_i = 1'b1;
    nreads = 0; addr_bad = 0; exp_addr = p;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) begin
      fails++; checks++;
      $display("FAIL R9: actual no done expected done");
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 req", rd_req_o, 0);
    chk("R1 skip", skip_o, 0);
    chk("R1 intr", intr_o, 0);
    chk("R1 ptr", ptr_o, 16'h0000);
  endtask

  task automatic t_find();
    fill(); mem[8'h10] = 8'h61; mem[8'h11] = 8'h62; mem[8'h12] = 8'h63; mem[8'h13] = 8'h58;
    launch(16'h0010, 16'h0058);
    wait_done();
    chk("R3 ptr", ptr_o, 16'h0013);
    chk("R3 skip", skip_o, 0);
    chk("R3 intr", intr_o, 0);
    chk("R8 reads", nreads, 4);
    chk("R8 addrs", addr_bad, 0);
    @(negedge clk);
    chk("R9 pulse", done_o, 0);
    repeat (3) @(negedge clk);
    chk("R9 hold", ptr_o, 16'h0013);
  endtask

  task automatic t_stop();
    fill(); mem[8'h22] = 8'h2E;
    launch(16'h0020, 16'h2E5A); // R2: stop byte high, search byte low
    wait_done();
    chk("R4 ptr", ptr_o, 16'h0023);
    chk("R4 skip", skip_o, 1);
    chk("R4 intr", intr_o, 0);
    // R2 swapped halves: 0x2E now the search byte
    launch(16'h0020, 16'h5A2E);
    wait_done();
    chk("R2 ptr", ptr_o, 16'h0022);
    chk("R2 skip", skip_o, 0);
  endtask

  task automatic t_equal();
    fill(); mem[8'h31] = 8'h41;
    launch(16'h0030, 16'h4141);
    wait_done();
    chk("R5 ptr", ptr_o, 16'h0031);
    chk("R5 skip", skip_o, 0);
  endtask

  task automatic t_irq();
    fill(); mem[8'h45] = 8'h51; mem[8'h50] = 8'h2E;
    irq_i = 1'b1;
    launch(16'h0040, 16'h2E51);
    wait_done();
    chk("R6 ptr", ptr_o, 16'h0041);
    chk("R6 intr", intr_o, 1);
    chk("R6 skip", skip_o, 0);
    chk("R6 reads", nreads, 1);
    irq_i = 1'b0;
    launch(ptr_o, 16'h2E51);
    wait_done();
    chk("R6 resume ptr", ptr_o, 16'h0045);
    chk("R6 resume intr", intr_o, 0);
    irq_i = 1'b1;
    launch(16'h0045, 16'h2E51);
    wait_done();
    chk("R6 find over irq", ptr_o, 16'h0045);
    chk("R6 find over irq intr", intr_o, 0);
    launch(16'h0050, 16'h2E51);
    wait_done();
    chk("R6 stop over irq skip", skip_o, 1);
    chk("R6 stop over irq intr", intr_o, 0);
    irq_i = 1'b0;
  endtask

  task automatic t_wrap();
    fill(); mem[8'hFE] = 8'h11; mem[8'hFF] = 8'h12; mem[8'h00] = 8'h7E;
    launch(16'hFFFE, 16'h007E);
    wait_done();
    chk("R7 ptr", ptr_o, 16'h0000);
    chk("R7 reads", nreads, 3);
    chk("R7 addrs", addr_bad, 0);
  endtask

  task automatic t_busy_start();
    fill(); mem[8'h65] = 8'h44; mem[8'h82] = 8'h44;
    launch(16'h0060, 16'h0044);
    @(negedge clk);
    chk("R10 busy", busy_o, 1);
    ptr_i = 16'h0080; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk("R10 ptr", ptr_o, 16'h0065);
    chk("R10 addrs", addr_bad, 0);
  endtask

  initial begin
    #2ms;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; key_i = '0; ptr_i = '0; irq_i = 1'b0;
    fill();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_find();
    t_stop();
    t_equal();
    t_irq();
    t_wrap();
    t_busy_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule